// File: doc/BRIEF.md
# Frame Readback Serializer

This block streams the contents of a small frame-organized configuration store out of one serial pin, one bit for each rising edge of the readback clock. A rising edge on the trigger input starts a pass over all frames. The stream opens with a short run of high preamble bits. Every frame is then sent as a low start bit followed by the frame word, most significant bit first. When the last frame has been sent, the pin returns high and the engine goes idle. The engine fetches each frame word through a read port while a fetch window is open. That window covers the last few cycles before the start bit of the frame. The word is taken at the edge that drives the start bit, so a location that logic has rewritten (for example a store used as user RAM) is streamed with its current contents.

Two static options shape a pass:
- **Capture.** When capture is enabled, the rising trigger edge also samples a set of live user signals. Their inverted values replace the lowest bits of frame 0.
- **Abort.** When abort is enabled, a falling trigger edge ends the pass early. The engine then waits through a recovery period of one clock per frame before it accepts a new trigger.

The trigger is synchronized and edge-detected inside the readback clock domain.

Top module: `frame_readout`

## Requirements
- R1: While reset is asserted and right after it is released, ser_out is 1, rb_active is 0 and rd_en is 0.
- R2: A trigger rising edge seen while idle starts a pass. A trigger set up before clock edge E1 is acted on at edge E3. rb_active is then 1 for exactly LEAD + NFRAMES*(FRAME_BITS+1) cycles and 0 at all other times.
- R3: During a pass, ser_out carries LEAD ones, then NFRAMES frames. Frame k is a 0 start bit followed by word k, bit FRAME_BITS-1 first and bit 0 last. After the last frame, ser_out is 1 and the engine is idle.
- R4: rd_en is 1 in exactly the LEAD cycles that come before each start bit, and rd_addr holds that frame's index during them. The word is taken from rd_data at the edge that drives the start bit, so a change made to a frame before its fetch window appears in the stream.
- R5: With cap_en at 1 when the pass is accepted, bits CAP_BITS-1..0 of frame 0 carry the inverse of usr_sig. usr_sig is sampled at the accepting edge.
- R6: With cap_en at 0, frame 0 is sent exactly as stored. No other bit of any frame is ever inverted.
- R7: With abort_en at 1, a trigger falling edge during a pass stops it at the third edge after the fall is sampled. rb_active and rd_en go to 0 and ser_out goes to 1.
- R8: After an abort, the engine ignores trigger rising edges for NFRAMES cycles. After that, a new trigger starts a full pass.
- R9: With abort_en at 0, a trigger falling edge during a pass has no effect, and the pass completes unchanged.
- R10: A trigger rising edge during a pass is ignored. The pass is not restarted or lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous readback trigger |
| cap_en | input | 1 | Capture option: insert inverted user signals into frame 0 |
| abort_en | input | 1 | Abort option: a falling trigger edge ends a pass |
| usr_sig | input | CAP_BITS | Live user signals sampled when a pass starts |
| rd_en | output | 1 | Fetch window open; rd_addr is valid |
| rd_addr | output | AW | Index of the frame being fetched |
| rd_data | input | FRAME_BITS | Frame word at rd_addr (asynchronous read) |
| ser_out | output | 1 | Serial readback data |
| rb_active | output | 1 | High while a pass is in progress |

## Verification
The assertions rely on three conditions being met, and the stimulus keeps to all three:
- **Frame and window sizes.** FRAME_BITS is at least LEAD, so fetch windows never overlap or merge across frames. The bench uses the defaults of 32 and 6.
- **Stable memory in the window.** The store changes only outside a frame's fetch window. The bench's single mid-pass rewrite targets the last frame long before its window opens.
- **Stable options and user signals.** The option pins and usr_sig stay stable while a pass runs. The bench changes them only while the engine is idle, with several cycles of margin.

// File: rtl/frame_readout_pkg.sv
package frame_readout_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REINIT = 2'd2
    } rb_state_e;
endpackage

// File: rtl/frame_readout_sync.sv
// Two-flop synchronizer with one extra stage for edge detection.
module frame_readout_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [2:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise = pipe_q[1] & ~pipe_q[2];
    assign fall = ~pipe_q[1] & pipe_q[2];
endmodule

// File: rtl/frame_readout_cap.sv
// Snapshot of user signals (stored inverted) and merge into frame 0.
module frame_readout_cap #(
    parameter int FRAME_BITS = 32,
    parameter int CAP_BITS   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grab,
    input  logic                  cap_on,
    input  logic [CAP_BITS-1:0]   usr,
    input  logic                  first,
    input  logic [FRAME_BITS-1:0] word_in,
    output logic [FRAME_BITS-1:0] word_out
);
    typedef struct packed {
        logic [CAP_BITS-1:0] snap;
        logic                on;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (grab) begin
            cap_d.on = cap_on;
            if (cap_on) cap_d.snap = ~usr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        word_out = word_in;
        if (first && cap_q.on) word_out[CAP_BITS-1:0] = cap_q.snap;
    end
endmodule

// File: rtl/frame_readout.sv
module frame_readout
    import frame_readout_pkg::*;
#(
    parameter int NFRAMES    = 8,
    parameter int FRAME_BITS = 32,
    parameter int CAP_BITS   = 4,
    parameter int LEAD       = 6,
    localparam int AW        = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_in,
    input  logic                  cap_en,
    input  logic                  abort_en,
    input  logic [CAP_BITS-1:0]   usr_sig,
    output logic                  rd_en,
    output logic [AW-1:0]         rd_addr,
    input  logic [FRAME_BITS-1:0] rd_data,
    output logic                  ser_out,
    output logic                  rb_active
);
    localparam int MAXC = (FRAME_BITS > NFRAMES) ? FRAME_BITS : NFRAMES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int FW   = $clog2(NFRAMES + 1);

    typedef struct packed {
        rb_state_e             st;
        logic [CW-1:0]         cnt;
        logic [FW-1:0]         fr;
        logic [FRAME_BITS-1:0] sh;
        logic                  dout;
    } seq_t;

    seq_t seq_d, seq_q;
    logic trig_rise, trig_fall, grab;
    logic [FRAME_BITS-1:0] frame_word;

    frame_readout_sync u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (trig_in),
        .rise (trig_rise),
        .fall (trig_fall)
    );

    frame_readout_cap #(
        .FRAME_BITS (FRAME_BITS),
        .CAP_BITS   (CAP_BITS)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (grab),
        .cap_on   (cap_en),
        .usr      (usr_sig),
        .first    (seq_q.fr == '0),
        .word_in  (rd_data),
        .word_out (frame_word)
    );

    always_comb begin
        seq_d = seq_q;
        grab  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (trig_rise) begin
                    seq_d.st   = ST_RUN;
                    seq_d.cnt  = CW'(LEAD - 1);
                    seq_d.fr   = '0;
                    seq_d.sh   = '1;
                    seq_d.dout = 1'b1;
                    grab       = 1'b1;
                end
            end
            ST_RUN: begin
                if (abort_en && trig_fall) begin
                    seq_d.st   = ST_REINIT;
                    seq_d.cnt  = CW'(NFRAMES - 1);
                    seq_d.sh   = '1;
                    seq_d.dout = 1'b1;
                end else if (seq_q.cnt == '0) begin
                    if (seq_q.fr < FW'(NFRAMES)) begin
                        // start bit goes out while the fetched word is loaded
                        seq_d.dout = 1'b0;
                        seq_d.sh   = frame_word;
                        seq_d.cnt  = CW'(FRAME_BITS);
                        seq_d.fr   = seq_q.fr + 1'b1;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.dout = 1'b1;
                    end
                end else begin
                    seq_d.dout = seq_q.sh[FRAME_BITS-1];
                    seq_d.sh   = {seq_q.sh[FRAME_BITS-2:0], 1'b1};
                    seq_d.cnt  = seq_q.cnt - 1'b1;
                end
            end
            ST_REINIT: begin
                if (seq_q.cnt == '0) seq_d.st  = ST_IDLE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.cnt  <= '0;
            seq_q.fr   <= '0;
            seq_q.sh   <= '1;
            seq_q.dout <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rb_active = (seq_q.st == ST_RUN);
    assign rd_en     = rb_active && (seq_q.cnt < CW'(LEAD)) && (seq_q.fr < FW'(NFRAMES));
    assign rd_addr   = seq_q.fr[AW-1:0];
    assign ser_out   = seq_q.dout;
endmodule

// File: rtl/frame_readout_chk.sv
module frame_readout_chk #(
    parameter int NFRAMES    = 8,
    parameter int FRAME_BITS = 32,
    parameter int LEAD       = 6,
    localparam int AW        = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rb_active,
    input logic          ser_out,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr
);
    localparam int MAXLEN = LEAD + NFRAMES * (FRAME_BITS + 1);
    localparam int RW     = $clog2(MAXLEN + 2);

    logic [RW-1:0] run_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len_q <= '0;
        else if (rb_active) run_len_q <= run_len_q + 1'b1;
        else                run_len_q <= '0;
    end

    AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_active |-> ser_out); // R3

    AST_FETCH_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rb_active); // R4

    AST_FETCH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> $stable(rd_addr)); // R4

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_active && $fell(rd_en)) |-> !ser_out); // R3

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        rb_active |-> (run_len_q < RW'(MAXLEN))); // R2
endmodule

bind frame_readout frame_readout_chk #(
    .NFRAMES    (NFRAMES),
    .FRAME_BITS (FRAME_BITS),
    .LEAD       (LEAD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_active (rb_active),
    .ser_out   (ser_out),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
);

// File: tb/sim_frame_readout.sv
`timescale 1ns/1ps
module sim_frame_readout;
    localparam int NF    = 8;
    localparam int FB    = 32;
    localparam int CB    = 4;
    localparam int LD    = 6;
    localparam int AW    = 3;
    localparam int TOTAL = LD + NF * (FB + 1);

    logic clk = 1'b0;
    logic rst_n, trig_in, cap_en, abort_en;
    logic [CB-1:0] usr_sig;
    logic rd_en, ser_out, rb_active;
    logic [AW-1:0] rd_addr;
    logic [FB-1:0] rd_data;
    logic [FB-1:0] mem [NF];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    assign rd_data = mem[rd_addr];

    frame_readout #(.NFRAMES(NF), .FRAME_BITS(FB), .CAP_BITS(CB), .LEAD(LD)) u0 (
        .clk (clk), .rst_n (rst_n), .trig_in (trig_in), .cap_en (cap_en),
        .abort_en (abort_en), .usr_sig (usr_sig), .rd_en (rd_en),
        .rd_addr (rd_addr), .rd_data (rd_data), .ser_out (ser_out),
        .rb_active (rb_active)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic exp_bit(input int i, input bit cap_on, input logic [CB-1:0] usr);
        int j, f, p, b;
        if (i < LD) return 1'b1;
        j = i - LD;
        f = j / (FB + 1);
        p = j % (FB + 1);
        if (p == 0) return 1'b0;
        b = FB - p;
        if (f == 0 && cap_on && b < CB) return ~usr[b];
        return mem[f][b];
    endfunction

    function automatic logic exp_fetch(input int i);
        int j, f, p;
        if (i < LD) return 1'b1;
        j = i - LD;
        f = j / (FB + 1);
        p = j % (FB + 1);
        return (p >= FB + 1 - LD) && (f < NF - 1);
    endfunction

    function automatic int exp_addr(input int i);
        if (i < LD) return 0;
        return (i - LD) / (FB + 1) + 1;
    endfunction

    task automatic fill_mem();
        for (int k = 0; k < NF; k++) mem[k] = $urandom;
    endtask

    task automatic go_idle();
        trig_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Raises the trigger and walks to the first active cycle (R2 latency).
    task automatic start_pass();
        trig_in = 1'b1;
        @(negedge clk);
        chk("R2", "not active one edge after trigger", 64'(rb_active), 64'd0);
        @(negedge clk);
        chk("R2", "not active two edges after trigger", 64'(rb_active), 64'd0);
        @(negedge clk);
    endtask

    // Samples a full pass; fall_at/rise_at/change_at < 0 mean unused.
    task automatic run_pass(input int fall_at, input int rise_at, input int change_at);
        bit cap_on = cap_en;
        logic [CB-1:0] usr = usr_sig;
        bit aborted = 0;
        start_pass();
        for (int i = 0; i < TOTAL; i++) begin
            if (abort_en && fall_at >= 0 && i == fall_at + 3) begin
                chk("R7", "rb_active after abort", 64'(rb_active), 64'd0);
                chk("R7", "ser_out after abort", 64'(ser_out), 64'd1);
                chk("R7", "rd_en after abort", 64'(rd_en), 64'd0);
                aborted = 1;
                break;
            end
            chk("R2", $sformatf("rb_active cycle %0d", i), 64'(rb_active), 64'd1);
            chk((i >= LD && i < LD + FB + 1) ? (cap_on ? "R5" : "R6") : "R3",
                $sformatf("ser_out cycle %0d", i), 64'(ser_out), 64'(exp_bit(i, cap_on, usr)));
            chk("R4", $sformatf("rd_en cycle %0d", i), 64'(rd_en), 64'(exp_fetch(i)));
            if (exp_fetch(i))
                chk("R4", $sformatf("rd_addr cycle %0d", i), 64'(rd_addr), 64'(exp_addr(i)));
            if (i == fall_at)   trig_in = 1'b0;
            if (i == rise_at)   trig_in = 1'b1;
            if (i == change_at) mem[NF-1] = $urandom;
            @(negedge clk);
        end
        if (!aborted) begin
            chk("R2", "rb_active after final frame", 64'(rb_active), 64'd0);
            chk("R3", "ser_out after final frame", 64'(ser_out), 64'd1);
            @(negedge clk);
            chk("R10", "no restart after pass", 64'(rb_active), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; trig_in = 1'b0; cap_en = 1'b0; abort_en = 1'b0; usr_sig = '0;
        fill_mem();
        repeat (3) @(negedge clk);
        chk("R1", "ser_out in reset", 64'(ser_out), 64'd1);
        chk("R1", "rb_active in reset", 64'(rb_active), 64'd0);
        chk("R1", "rd_en in reset", 64'(rd_en), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "ser_out after reset", 64'(ser_out), 64'd1);
        chk("R1", "rb_active after reset", 64'(rb_active), 64'd0);

        // R5: capture on, memory bits at capture spots equal usr so inversion shows
        cap_en = 1'b1; usr_sig = 4'b1010;
        mem[0][CB-1:0] = 4'b1010;
        @(negedge clk);
        run_pass(-1, -1, -1);
        go_idle();

        // R6: capture off, stored bits pass unchanged
        cap_en = 1'b0;
        @(negedge clk);
        run_pass(-1, -1, -1);
        go_idle();

        // R4: last frame rewritten long before its fetch window
        run_pass(-1, -1, LD + 5);
        go_idle();

        // R9 and R10: fall then rise mid-pass with abort off
        abort_en = 1'b0;
        run_pass(LD + 20, LD + 60, -1);
        go_idle();

        // R7 then R8: abort, a trigger during recovery, then a fresh pass
        abort_en = 1'b1;
        @(negedge clk);
        run_pass(LD + 40, -1, -1);
        trig_in = 1'b1;
        for (int k = 0; k < 20; k++) begin
            chk("R8", $sformatf("trigger ignored during recovery, cycle %0d", k),
                64'(rb_active), 64'd0);
            @(negedge clk);
        end
        go_idle();
        run_pass(-1, -1, -1);
        go_idle();
        abort_en = 1'b0;

        // random passes
        for (int r = 0; r < 6; r++) begin
            fill_mem();
            cap_en  = 1'($urandom);
            usr_sig = CB'($urandom);
            @(negedge clk);
            run_pass(-1, -1, -1);
            go_idle();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule